// File: doc/BRIEF.md
# Event-Triggered Register Write Replay Engine

This block replays a prepared list of register writes onto an internal register bus. Software places the list in memory as a run of entries. Each entry is a register address word followed by a value word. Software then gives the engine the first and last byte of that window and picks what starts a replay: a software kick, a vertical-sync pulse or a line-counter event.

Once armed, the channel waits for the chosen event. It then fetches each entry through a single-outstanding memory read port and presents the write on a valid/ready register port. It walks the window strictly from first entry to last. When it is done it raises a sticky completion interrupt. The channel stays armed, so the next selected event replays the same list. Typical use is to apply a whole frame's worth of display register updates at the vertical blanking point.

Top module: `evtRegReplay`

## Requirements
- R1: An entry is 8 bytes. The word at the entry base is the register address, and only its low REG_AW bits drive `regWrAddr`. The word at base+4 is the value driven on `regWrData`.
- R2: The window is inclusive. `csrAddr`=1 holds the start byte address and `csrAddr`=2 holds the end byte address. A list of N entries ends at start+8N-1, and a window ending at start+7 yields exactly one write. No read is issued above the end address or below the start address.
- R3: Register writes come out in list order, from the lowest entry address to the highest.
- R4: The mode register is at `csrAddr`=3. Its bits [1:0] select the trigger: 0 stop, 1 software kick, 2 `vsyncPulse`, 3 `lineEvt`. Only the selected event starts a replay. The software kick is a write of 1 to bit 2 at `csrAddr`=0. Mode resets to 0.
- R5: With trigger select 0, no event starts a replay. This holds even when the channel was armed for another event just before.
- R6: Mode bit 2 is the write-direction flag. While it is 0, every trigger is ignored: no reads, no writes, no interrupt.
- R7: Mode bit 3 is address increment. When it is 1, the first entry's address word gives the register address and each later entry uses the previous address plus 1. The address words of those later entries are ignored. When it is 0, every entry supplies its own address.
- R8: Writing 1 to bit 0 at `csrAddr`=0 aborts any replay in progress, returns the engine to idle and clears the interrupt. The engine accepts a new trigger afterwards.
- R9: Completion sets `irq` and status bit 0, read at `csrAddr`=0. Writing 1 to bit 1 at `csrAddr`=0 clears it. Status bit 1 reads 1 while a replay is in progress.
- R10: A selected event that arrives during a replay is ignored, not queued. After completion the channel remains armed and replays again on the next selected event.
- R11: If end < start+7, a trigger completes at once with the interrupt set and no memory read or register write.
- R12: `memReq` stays high with a stable `memAddr` until `memValid` returns the word. At most one read is outstanding.
- R13: While `regWrValid` is high and `regWrReady` is low, `regWrValid`, `regWrAddr` and `regWrData` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrWrEn | input | 1 | Control register write strobe |
| csrAddr | input | 2 | Control register word index |
| csrWrData | input | 32 | Control register write data |
| csrRdData | output | 32 | Control register read data (combinational on csrAddr) |
| vsyncPulse | input | 1 | Vertical-sync event, one cycle per event |
| lineEvt | input | 1 | Line-counter event, one cycle per event |
| memReq | output | 1 | Memory read request |
| memAddr | output | MEM_AW | Memory read byte address |
| memValid | input | 1 | Read data valid, completes the request |
| memData | input | 32 | Read data word |
| regWrValid | output | 1 | Register write valid |
| regWrAddr | output | REG_AW | Register write address |
| regWrData | output | 32 | Register write value |
| regWrReady | input | 1 | Register bus accepts the write |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench builds the engine with MEM_AW=16 and REG_AW=12. The narrow register address lets an address word such as 0xF123 show that only its low bits (0x123) reach the bus. The 16-bit memory address lets a 64-word memory model, indexed by byte-address bits [7:2], hold several lists at different bases. The model's response latency is adjustable, from same-cycle answers up to 40-cycle stalls. That range brings within reach the request-hold rule, a trigger landing mid-replay, and an abort while a read is pending. A ready pattern that stalls two cycles out of three exercises the write hold.

// File: rtl/replay_pkg.sv
package replay_pkg;

  localparam int CSR_AW      = 2;
  localparam int WORD_W      = 32;
  localparam int ENTRY_BYTES = 8;

  localparam logic [CSR_AW-1:0] CSR_CTRL  = 2'd0;
  localparam logic [CSR_AW-1:0] CSR_START = 2'd1;
  localparam logic [CSR_AW-1:0] CSR_END   = 2'd2;
  localparam logic [CSR_AW-1:0] CSR_MODE  = 2'd3;

  typedef enum logic [1:0] {
    TRIG_STOP   = 2'd0,
    TRIG_MANUAL = 2'd1,
    TRIG_VSYNC  = 2'd2,
    TRIG_LINE   = 2'd3
  } trigSel_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_DATA,
    ST_WRITE,
    ST_DONE
  } state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPtr;    // latch window and mode at sequence start
    logic advPtr;     // step to next entry
    logic capAddr;    // capture address word
    logic capData;    // capture value word
    logic dataPhase;  // read the value word of the current entry
  } dpStrobe_t;

endpackage

// File: rtl/replayDatapath.sv
module replayDatapath
  import replay_pkg::*;
#(
  parameter int MEM_AW = 32,
  parameter int REG_AW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [MEM_AW-1:0]   startAddr,
  input  logic [MEM_AW-1:0]   endAddr,
  input  logic                incMode,
  input  logic [WORD_W-1:0]   memData,
  input  logic                memValid,
  input  logic                memReq,
  input  logic                regWrValid,
  input  logic                regWrReady,
  output logic [MEM_AW-1:0]   memAddr,
  output logic [REG_AW-1:0]   regWrAddr,
  output logic [WORD_W-1:0]   regWrData,
  output logic                emptyWin,
  output logic                moreEntries
);

  localparam int EW = MEM_AW + 1;
  localparam logic [EW-1:0] LAST_OFS = EW'(ENTRY_BYTES - 1);
  localparam logic [EW-1:0] NEXT_END = EW'(2 * ENTRY_BYTES - 1);

  logic [MEM_AW-1:0] ptr;
  logic [MEM_AW-1:0] endLat;
  logic              incLat;
  logic              firstEntry;
  logic [REG_AW-1:0] regAddrQ;
  logic [WORD_W-1:0] regDataQ;
  logic              unusedHighBits;

  assign unusedHighBits = ^memData[WORD_W-1:REG_AW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr        <= '0;
      endLat     <= '0;
      incLat     <= 1'b0;
      firstEntry <= 1'b0;
      regAddrQ   <= '0;
      regDataQ   <= '0;
    end else begin
      if (strb.loadPtr) begin
        ptr        <= startAddr;
        endLat     <= endAddr;
        incLat     <= incMode;
        firstEntry <= 1'b1;
      end else if (strb.advPtr) begin
        ptr        <= ptr + MEM_AW'(ENTRY_BYTES);
        firstEntry <= 1'b0;
        if (incLat) regAddrQ <= regAddrQ + REG_AW'(1);
      end
      if (strb.capAddr && (!incLat || firstEntry))
        regAddrQ <= memData[REG_AW-1:0];
      if (strb.capData)
        regDataQ <= memData;
    end
  end

  assign memAddr     = ptr + (strb.dataPhase ? MEM_AW'(4) : MEM_AW'(0));
  assign regWrAddr   = regAddrQ;
  assign regWrData   = regDataQ;
  assign emptyWin    = {1'b0, endAddr} < ({1'b0, startAddr} + LAST_OFS);
  assign moreEntries = ({1'b0, ptr} + NEXT_END) <= {1'b0, endLat};

  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (({1'b0, memAddr} + EW'(3)) <= {1'b0, endLat})); // R2
  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (!memReq || $stable(memAddr))); // R12
  AST_WR_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrValid && !regWrReady) |=> (!regWrValid || ($stable(regWrAddr) && $stable(regWrData)))); // R13

endmodule

// File: rtl/replayCtrl.sv
module replayCtrl
  import replay_pkg::*;
#(
  parameter int MEM_AW = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csrWrEn,
  input  logic [CSR_AW-1:0]   csrAddr,
  input  logic [WORD_W-1:0]   csrWrData,
  output logic [WORD_W-1:0]   csrRdData,
  input  logic                vsyncPulse,
  input  logic                lineEvt,
  input  logic                memValid,
  input  logic                regWrReady,
  input  logic                emptyWin,
  input  logic                moreEntries,
  output logic [MEM_AW-1:0]   startAddr,
  output logic [MEM_AW-1:0]   endAddr,
  output logic                incMode,
  output dpStrobe_t           strb,
  output logic                memReq,
  output logic                regWrValid,
  output logic                irq
);

  trigSel_t trigSel;
  logic     dirWrite;
  state_t   state, stateNext;
  logic     ctrlWr, softRst, irqClr, kick;
  logic     evtSel, trigHit, irqSet, busy;

  assign ctrlWr  = csrWrEn && (csrAddr == CSR_CTRL);
  assign softRst = ctrlWr && csrWrData[0];
  assign irqClr  = ctrlWr && csrWrData[1];
  assign kick    = ctrlWr && csrWrData[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr <= '0;
      endAddr   <= '0;
      trigSel   <= TRIG_STOP;
      dirWrite  <= 1'b0;
      incMode   <= 1'b0;
    end else if (csrWrEn) begin
      case (csrAddr)
        CSR_START: startAddr <= csrWrData[MEM_AW-1:0];
        CSR_END:   endAddr   <= csrWrData[MEM_AW-1:0];
        CSR_MODE: begin
          trigSel  <= trigSel_t'(csrWrData[1:0]);
          dirWrite <= csrWrData[2];
          incMode  <= csrWrData[3];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (trigSel)
      TRIG_MANUAL: evtSel = kick;
      TRIG_VSYNC:  evtSel = vsyncPulse;
      TRIG_LINE:   evtSel = lineEvt;
      default:     evtSel = 1'b0;
    endcase
  end

  assign trigHit = evtSel && dirWrite && !softRst;

  always_comb begin
    stateNext = state;
    strb      = '0;
    irqSet    = 1'b0;
    case (state)
      ST_IDLE: if (trigHit) begin
        strb.loadPtr = 1'b1;
        stateNext    = emptyWin ? ST_DONE : ST_RD_ADDR;
      end
      ST_RD_ADDR: if (memValid) begin
        strb.capAddr = 1'b1;
        stateNext    = ST_RD_DATA;
      end
      ST_RD_DATA: begin
        strb.dataPhase = 1'b1;
        if (memValid) begin
          strb.capData = 1'b1;
          stateNext    = ST_WRITE;
        end
      end
      ST_WRITE: if (regWrReady) begin
        if (moreEntries) begin
          strb.advPtr = 1'b1;
          stateNext   = ST_RD_ADDR;
        end else begin
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        irqSet    = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      state <= softRst ? ST_IDLE : stateNext;
      if (softRst)     irq <= 1'b0;
      else if (irqSet) irq <= 1'b1;
      else if (irqClr) irq <= 1'b0;
    end
  end

  assign memReq     = (state == ST_RD_ADDR) || (state == ST_RD_DATA);
  assign regWrValid = (state == ST_WRITE);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    case (csrAddr)
      CSR_CTRL:  csrRdData = {30'd0, busy, irq};
      CSR_START: csrRdData = WORD_W'(startAddr);
      CSR_END:   csrRdData = WORD_W'(endAddr);
      default:   csrRdData = {28'd0, incMode, dirWrite, trigSel};
    endcase
  end

  AST_STOP_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && trigSel == TRIG_STOP) |=> (state == ST_IDLE)); // R5
  AST_NO_DIR_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !dirWrite) |=> (state == ST_IDLE)); // R6
  AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && !softRst) |=> irq); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid && !softRst) |=> memReq); // R12
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (regWrValid && !regWrReady && !softRst) |=> regWrValid); // R13
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!memReq && !regWrValid && !irq)); // R8

endmodule

// File: rtl/evtRegReplay.sv
module evtRegReplay
  import replay_pkg::*;
#(
  parameter int MEM_AW = 32,
  parameter int REG_AW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csrWrEn,
  input  logic [CSR_AW-1:0]    csrAddr,
  input  logic [WORD_W-1:0]    csrWrData,
  output logic [WORD_W-1:0]    csrRdData,
  input  logic                 vsyncPulse,
  input  logic                 lineEvt,
  output logic                 memReq,
  output logic [MEM_AW-1:0]    memAddr,
  input  logic                 memValid,
  input  logic [WORD_W-1:0]    memData,
  output logic                 regWrValid,
  output logic [REG_AW-1:0]    regWrAddr,
  output logic [WORD_W-1:0]    regWrData,
  input  logic                 regWrReady,
  output logic                 irq
);

  dpStrobe_t         strb;
  logic [MEM_AW-1:0] startAddr, endAddr;
  logic              incMode, emptyWin, moreEntries;

  replayCtrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csrWrEn(csrWrEn), .csrAddr(csrAddr), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .vsyncPulse(vsyncPulse), .lineEvt(lineEvt),
    .memValid(memValid), .regWrReady(regWrReady),
    .emptyWin(emptyWin), .moreEntries(moreEntries),
    .startAddr(startAddr), .endAddr(endAddr), .incMode(incMode),
    .strb(strb), .memReq(memReq), .regWrValid(regWrValid), .irq(irq)
  );

  replayDatapath #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .startAddr(startAddr), .endAddr(endAddr), .incMode(incMode),
    .memData(memData), .memValid(memValid), .memReq(memReq),
    .regWrValid(regWrValid), .regWrReady(regWrReady),
    .memAddr(memAddr), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .emptyWin(emptyWin), .moreEntries(moreEntries)
  );

endmodule

// File: tb/evtRegReplay_bench.sv
`timescale 1ns/1ps
module evtRegReplay_bench;
  localparam int MEM_AW = 16;
  localparam int REG_AW = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, csrWrEn, vsyncPulse, lineEvt, memReq, memValid, regWrValid, regWrReady, irq;
  logic [1:0] csrAddr;
  logic [31:0] csrWrData, csrRdData, memData, regWrData;
  logic [MEM_AW-1:0] memAddr;
  logic [REG_AW-1:0] regWrAddr;

  evtRegReplay #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) u_evtRegReplay (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrAddr(csrAddr), .csrWrData(csrWrData),
    .csrRdData(csrRdData), .vsyncPulse(vsyncPulse), .lineEvt(lineEvt),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .regWrValid(regWrValid), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regWrReady(regWrReady), .irq(irq)
  );

  int errors = 0, checks = 0;
  logic [31:0] mem [0:63];
  int memLat = 0, rdCount = 0, rdMin = 'hFFFF, rdMax = 0, viol12 = 0, viol13 = 0;
  int waitCnt = 0;
  logic [MEM_AW-1:0] lastAddr = '0;
  logic [REG_AW-1:0] wrA [0:31];
  logic [31:0] wrD [0:31];
  int wrN = 0, cyc = 0;
  bit stallMode = 0, pendW = 0;
  logic [REG_AW-1:0] pA;
  logic [31:0] pD;

  // Memory model: one outstanding read, adjustable latency
  initial begin
    memValid = 1'b0; memData = '0;
    forever begin
      @(negedge clk);
      if (memValid) memValid = 1'b0;
      else if (memReq) begin
        if (waitCnt > 0 && memAddr != lastAddr) viol12++;
        lastAddr = memAddr;
        if (waitCnt >= memLat) begin
          memValid = 1'b1; memData = mem[memAddr[7:2]]; waitCnt = 0; rdCount++;
          if (int'(memAddr) < rdMin) rdMin = int'(memAddr);
          if (int'(memAddr) > rdMax) rdMax = int'(memAddr);
        end else waitCnt++;
      end else waitCnt = 0;
    end
  end

  // Register bus model and write logger
  initial begin
    regWrReady = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pendW && (!regWrValid || regWrAddr != pA || regWrData != pD)) viol13++;
      regWrReady = stallMode ? (cyc % 3 == 0) : 1'b1;
      pendW = regWrValid && !regWrReady; pA = regWrAddr; pD = regWrData;
      if (regWrValid && regWrReady && wrN < 32) begin
        wrA[wrN] = regWrAddr; wrD[wrN] = regWrData; wrN++;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic csrWr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); csrWrEn = 1'b1; csrAddr = a; csrWrData = d;
    @(negedge clk); csrWrEn = 1'b0;
  endtask

  task automatic csrRd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); csrAddr = a; #1; d = csrRdData;
  endtask

  task automatic pulseV();
    @(negedge clk); vsyncPulse = 1'b1; @(negedge clk); vsyncPulse = 1'b0;
  endtask

  task automatic pulseL();
    @(negedge clk); lineEvt = 1'b1; @(negedge clk); lineEvt = 1'b0;
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clearLog();
    wrN = 0; rdCount = 0; rdMin = 'hFFFF; rdMax = 0;
  endtask

  task automatic setup3(input logic [31:0] endA);
    csrWr(2'd0, 32'h2);
    csrWr(2'd1, 32'h40);
    csrWr(2'd2, endA);
    clearLog();
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R9", "irq after reset", irq, 0);
    chk("R12", "memReq after reset", memReq, 0);
    chk("R13", "regWrValid after reset", regWrValid, 0);
    csrRd(2'd3, d); chk("R4", "mode after reset", d, 0);
  endtask

  task automatic testManual();
    logic [31:0] d;
    setup3(32'h57);
    csrWr(2'd3, 32'h5);
    csrWr(2'd0, 32'h4);
    waitIrq();
    chk("R2", "write count 3-entry window", wrN, 3);
    chk("R1", "addr0 low bits", wrA[0], 12'h123);
    chk("R1", "data0", wrD[0], 32'hA1);
    chk("R3", "addr1 order", wrA[1], 12'h045);
    chk("R3", "addr2 order", wrA[2], 12'h7FF);
    chk("R3", "data2 order", wrD[2], 32'hC3);
    chk("R2", "lowest read", rdMin, 'h40);
    chk("R2", "highest read", rdMax, 'h54);
    chk("R2", "read count", rdCount, 6);
    csrRd(2'd0, d);
    chk("R9", "status irq set, idle", d, 1);
    chk("R9", "irq pin", irq, 1);
    csrWr(2'd0, 32'h2);
    chk("R9", "irq cleared by write 1", irq, 0);
  endtask

  task automatic testOneEntry();
    setup3(32'h47);
    csrWr(2'd0, 32'h4);
    waitIrq();
    chk("R2", "end=start+7 gives one write", wrN, 1);
    chk("R2", "one-entry reads", rdMax, 'h44);
  endtask

  task automatic testVsync();
    setup3(32'h57);
    csrWr(2'd3, 32'h6);
    pulseL(); repeat (20) @(negedge clk);
    chk("R4", "line event ignored on vsync select", wrN, 0);
    pulseV(); waitIrq();
    chk("R4", "vsync replays", wrN, 3);
    chk("R3", "vsync last addr", wrA[2], 12'h7FF);
  endtask

  task automatic testLineStall();
    setup3(32'h57);
    stallMode = 1;
    csrWr(2'd3, 32'h7);
    pulseV(); repeat (20) @(negedge clk);
    chk("R4", "vsync ignored on line select", wrN, 0);
    pulseL(); waitIrq();
    chk("R4", "line event replays", wrN, 3);
    chk("R13", "stalled data1", wrD[1], 32'hB2);
    stallMode = 0;
  endtask

  task automatic testBusyTrigger();
    logic [31:0] d;
    setup3(32'h57);
    memLat = 3;
    csrWr(2'd3, 32'h6);
    pulseV(); repeat (6) @(negedge clk);
    csrRd(2'd0, d); chk("R9", "busy status mid-run", d[1], 1);
    pulseV(); waitIrq(); repeat (40) @(negedge clk);
    chk("R10", "trigger during replay not queued", wrN, 3);
    csrWr(2'd0, 32'h2);
    pulseV(); waitIrq();
    chk("R10", "still armed after completion", wrN, 6);
    chk("R10", "irq after rearmed run", irq, 1);
    memLat = 0;
  endtask

  task automatic testStop();
    setup3(32'h57);
    csrWr(2'd3, 32'h6);
    csrWr(2'd3, 32'h4);
    pulseV(); pulseL(); csrWr(2'd0, 32'h4);
    repeat (30) @(negedge clk);
    chk("R5", "stop: no writes", wrN, 0);
    chk("R5", "stop: no reads", rdCount, 0);
    chk("R5", "stop: no irq", irq, 0);
  endtask

  task automatic testDir();
    setup3(32'h57);
    csrWr(2'd3, 32'h1);
    csrWr(2'd0, 32'h4);
    repeat (30) @(negedge clk);
    chk("R6", "direction 0: no writes", wrN, 0);
    chk("R6", "direction 0: no reads", rdCount, 0);
    chk("R6", "direction 0: no irq", irq, 0);
  endtask

  task automatic testInc();
    csrWr(2'd0, 32'h2);
    csrWr(2'd1, 32'h80);
    csrWr(2'd2, 32'h9F);
    clearLog();
    csrWr(2'd3, 32'hD);
    csrWr(2'd0, 32'h4);
    waitIrq();
    chk("R7", "inc count", wrN, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R7", "inc addr", wrA[k], 12'h200 + k);
      chk("R7", "inc data", wrD[k], 32'h11 * (k + 1));
    end
  endtask

  task automatic testEmpty();
    setup3(32'h46);
    csrWr(2'd3, 32'h5);
    csrWr(2'd0, 32'h4);
    repeat (10) @(negedge clk);
    chk("R11", "empty window irq", irq, 1);
    chk("R11", "empty window writes", wrN, 0);
    chk("R11", "empty window reads", rdCount, 0);
    csrWr(2'd0, 32'h2);
    chk("R9", "clear after empty", irq, 0);
  endtask

  task automatic testSoftReset();
    logic [31:0] d;
    setup3(32'h57);
    memLat = 40;
    csrWr(2'd3, 32'h5);
    csrWr(2'd0, 32'h4);
    repeat (10) @(negedge clk);
    csrWr(2'd0, 32'h1);
    csrRd(2'd0, d);
    chk("R8", "status after abort", d, 0);
    chk("R8", "memReq after abort", memReq, 0);
    repeat (100) @(negedge clk);
    chk("R8", "no writes after abort", wrN, 0);
    chk("R8", "no irq after abort", irq, 0);
    memLat = 0;
    csrWr(2'd0, 32'h4);
    waitIrq();
    chk("R8", "new trigger after abort", wrN, 3);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[16] = 32'hF123; mem[17] = 32'hA1;
    mem[18] = 32'h0045; mem[19] = 32'hB2;
    mem[20] = 32'h37FF; mem[21] = 32'hC3;
    mem[32] = 32'h200; mem[33] = 32'h11;
    mem[34] = 32'hBAD; mem[35] = 32'h22;
    mem[36] = 32'hBAD; mem[37] = 32'h33;
    mem[38] = 32'hBAD; mem[39] = 32'h44;
    rstN = 1'b0; csrWrEn = 1'b0; csrAddr = '0; csrWrData = '0;
    vsyncPulse = 1'b0; lineEvt = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testManual();
    testOneEntry();
    testVsync();
    testLineStall();
    testBusyTrigger();
    testStop();
    testDir();
    testInc();
    testEmpty();
    testSoftReset();
    chk("R12", "read request held stable", viol12, 0);
    chk("R13", "write held until ready", viol13, 0);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual=expired expected=finished");
    finishRun();
  end

endmodule